// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous user port and an external asynchronous static RAM that has 19 address bits, a 16-bit data bus and two byte-lane strobes. A user request carries an address, a write flag, a 16-bit write word and two byte-enable bits. The controller then runs one complete memory access. When the access is finished it returns a one-cycle ready pulse, and for a read it also returns the read word.

Every wait-state count comes from the block's timing parameters. Each limit (address access, output-enable access, write pulse, write cycle, data setup before the end of the write, output float time) is divided by the clock period and rounded up, with a floor of one cycle. A different speed grade or clock therefore needs only new parameter values. All memory strobes are active low and come straight from registers. The bidirectional data bus is split into an output word, an output enable and an input word. Between requests the chip enable stays high, which keeps the memory in standby. A write that follows a read waits out a turnaround window so that the memory's outputs have floated before the controller drives the bus.

Top module: `sram16_lane_ctrl`

## Requirements
- R1: While `rst` is high, chip enable, write enable, output enable and both lane strobes are high, `mem_dq_oe` is low and `rdy` is low.
- R2: With no request pending, chip enable stays high and the data bus is not driven.
- R3: For a read, chip enable and output enable are low and write enable is high for RD_CYC cycles (4 at default parameters), with the address held stable. The word is captured on the last of those cycles.
- R4: On a read, `req_be[0]`=1 drives the lower-lane strobe low (bits 7:0) and `req_be[1]`=1 drives the upper-lane strobe low (bits 15:8). In `rdata`, a byte whose enable bit is 0 reads as 8'h00.
- R5: For a write, chip enable is low with write enable high and the bus driven for SU_CYC cycles. Write enable is then low for WP_CYC cycles. Address and data are stable while write enable is low, the write-enable pulse lasts at least 35 ns, chip enable is low for at least 70 ns and data is driven for at least 30 ns before the write ends.
- R6: A write changes only the bytes whose enable bit is 1. Bits 7:0 follow `req_be[0]` and bits 15:8 follow `req_be[1]`.
- R7: A write ends on a single edge that raises write enable and chip enable together and drops `mem_dq_oe`. The data word is unchanged on that edge.
- R8: `mem_dq_oe` is never high while output enable is low. Before the first driven cycle, output enable has been high for at least TA_CYC full cycles (2 at defaults, 30 ns float time).
- R9: `rdy` is high for exactly one cycle per request. Counted in clock edges from the accepting edge onward, ready rises on edge 5 for a read, on edge 5 for a write after a write or after reset, and on edge 7 for a write after a read.
- R10: Chip enable is high in the ready cycle, and a request still held during the ready cycle is not accepted again. Chip enable therefore toggles between any two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request, held until `rdy` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Byte enables: bit 0 lower lane, bit 1 upper lane |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower-lane strobe, active low |
| mem_ub_n | output | 1 | Upper-lane strobe, active low |
| mem_dq_o | output | 16 | Data driven to the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data read from the memory |

## Verification
A wrong state or a wrong wait-state counter in this block shows first as a strobe window of the wrong length, and the inline memory model measures that window on the very cycle the strobe rises. A missed turnaround shows as bus drive overlapping, or too soon after, output enable on the first driven cycle. A stale "last access was a read" flag shows at `rdy` two cycles early or late. Lane errors reach the ports only on a later read of the same address, so every partial write is followed by full-width and partial reads that compare against a reference memory.

// File: rtl/sram16_lane_ctrl.sv
`timescale 1ns/1ps
module sram16_lane_ctrl #(
  parameter int ADDR_W  = 19,
  parameter int CLK_PS  = 20000,
  parameter int T_AA_PS = 70000,
  parameter int T_OE_PS = 35000,
  parameter int T_WP_PS = 35000,
  parameter int T_WC_PS = 70000,
  parameter int T_DW_PS = 30000,
  parameter int T_HZ_PS = 30000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rdy,
  output logic [15:0]       rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [15:0]       mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_i
);

  function automatic int cyc(input int t_ps);
    int n;
    n = (t_ps + CLK_PS - 1) / CLK_PS;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = imax(cyc(T_AA_PS), cyc(T_OE_PS));
  localparam int WP_CYC = cyc(T_WP_PS);
  localparam int SU_CYC = imax(1, imax(cyc(T_WC_PS) - WP_CYC, cyc(T_DW_PS) - WP_CYC));
  localparam int TA_CYC = cyc(T_HZ_PS);
  localparam int MAX_C  = imax(imax(RD_CYC, WP_CYC), imax(SU_CYC, TA_CYC));
  localparam int CNT_W  = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TA, S_WSU, S_WP} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        be_q;
  logic              last_rd;
  logic [15:0]       lane_mask;
  logic              cnt_done;

  assign lane_mask = {{8{be_q[1]}}, {8{be_q[0]}}};
  assign cnt_done  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      be_q      <= '0;
      last_rd   <= 1'b0;
      rdy       <= 1'b0;
      rdata     <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      rdy <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req && !rdy) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
            be_q     <= req_be;
            if (!req_wr) begin
              state    <= S_RD;
              cnt      <= CNT_W'(RD_CYC - 1);
              mem_ce_n <= 1'b0;
              mem_oe_n <= 1'b0;
              mem_lb_n <= !req_be[0];
              mem_ub_n <= !req_be[1];
            end else if (last_rd) begin
              state <= S_TA;
              cnt   <= CNT_W'(TA_CYC - 1);
            end else begin
              state     <= S_WSU;
              cnt       <= CNT_W'(SU_CYC - 1);
              mem_ce_n  <= 1'b0;
              mem_lb_n  <= !req_be[0];
              mem_ub_n  <= !req_be[1];
              mem_dq_oe <= 1'b1;
            end
          end
        end
        S_RD: begin
          if (cnt_done) begin
            rdata    <= mem_dq_i & lane_mask;
            rdy      <= 1'b1;
            last_rd  <= 1'b1;
            state    <= S_IDLE;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_lb_n <= 1'b1;
            mem_ub_n <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_TA: begin
          if (cnt_done) begin
            state     <= S_WSU;
            cnt       <= CNT_W'(SU_CYC - 1);
            mem_ce_n  <= 1'b0;
            mem_lb_n  <= !be_q[0];
            mem_ub_n  <= !be_q[1];
            mem_dq_oe <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_WSU: begin
          if (cnt_done) begin
            state    <= S_WP;
            cnt      <= CNT_W'(WP_CYC - 1);
            mem_we_n <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_WP: begin
          if (cnt_done) begin
            state     <= S_IDLE;
            rdy       <= 1'b1;
            last_rd   <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram16_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram16_lane_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              rdy,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  p_no_drive_clash_r8: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  p_drive_after_float_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  p_oe_is_read_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  p_we_needs_ce_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

  p_write_end_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> ($fell(mem_dq_oe) && mem_ce_n));

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);

  p_ce_gap_r10: assert property (@(posedge clk) disable iff (rst)
    rdy |-> (mem_ce_n && mem_we_n && mem_oe_n));

endmodule

bind sram16_lane_ctrl sram16_lane_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rdy(rdy), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram16_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram16_lane_ctrl_tb;

  localparam int CK_NS  = 20;
  localparam int RD_EXP = (70 + CK_NS - 1) / CK_NS;
  localparam int WP_EXP = (35 + CK_NS - 1) / CK_NS;
  localparam int WC_EXP = (70 + CK_NS - 1) / CK_NS;
  localparam int DW_EXP = (30 + CK_NS - 1) / CK_NS;
  localparam int TA_EXP = (30 + CK_NS - 1) / CK_NS;
  localparam int LAT_RD = 1 + RD_EXP;
  localparam int LAT_WR = 1 + WC_EXP;
  localparam int LAT_WR_AFTER_RD = 1 + TA_EXP + WC_EXP;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rdy;
  logic [15:0] rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_o;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_i = 16'hA5A5;

  int total = 0;
  int bad = 0;
  bit last_was_rd = 1'b0;
  logic seen_lb, seen_ub;

  logic [15:0] mdl   [int];
  logic [15:0] ref_m [int];

  sram16_lane_ctrl u_dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rdy(rdy), .rdata(rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  always #(CK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_word(input logic [15:0] m [int], input int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  // inline memory model with timing monitor
  logic p_ce = 1, p_we = 1, p_oe = 1, p_dqoe = 0, p_lb = 1, p_ub = 1;
  logic [18:0] p_addr = '0;
  logic [15:0] p_dq = '0;
  int ce_run = 0, we_run = 0, oe_hi = 0, dqoe_run = 0;

  always @(negedge clk) begin
    int oe_now;
    logic [15:0] w;
    if (!rst) begin
      oe_now = mem_oe_n ? oe_hi + 1 : 0;
      if (mem_dq_oe && !mem_oe_n) chk(0, "R8 bus clash", 1, 0);
      if (mem_dq_oe && !p_dqoe && (oe_now - 1 < TA_EXP)) chk(0, "R8 float window", oe_now - 1, TA_EXP);
      if (!mem_ce_n && !p_ce && mem_addr != p_addr) chk(0, "R5 address moved during access", mem_addr, p_addr);
      if (!mem_we_n && !p_we && mem_dq_o != p_dq) chk(0, "R5 data moved during write", mem_dq_o, p_dq);
      if (!p_ce && !p_we && (mem_ce_n || mem_we_n)) begin
        if (we_run < WP_EXP) chk(0, "R5 write pulse", we_run, WP_EXP);
        if (ce_run < WC_EXP) chk(0, "R5 write cycle", ce_run, WC_EXP);
        if (dqoe_run < DW_EXP) chk(0, "R5 data setup", dqoe_run, DW_EXP);
        if (!(mem_ce_n && mem_we_n && !mem_dq_oe)) chk(0, "R7 write end edge", {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b110);
        if (mem_dq_o != p_dq) chk(0, "R7 data hold", mem_dq_o, p_dq);
        w = rd_word(mdl, int'(p_addr));
        if (!p_lb) w[7:0]  = p_dq[7:0];
        if (!p_ub) w[15:8] = p_dq[15:8];
        mdl[int'(p_addr)] = w;
      end
      if (!p_ce && p_we && !p_oe && mem_ce_n && ce_run < RD_EXP)
        chk(0, "R3 read window", ce_run, RD_EXP);
      ce_run   = mem_ce_n ? 0 : ce_run + 1;
      we_run   = mem_we_n ? 0 : we_run + 1;
      dqoe_run = mem_dq_oe ? dqoe_run + 1 : 0;
      oe_hi    = (oe_now > 1000) ? 1000 : oe_now;
    end
    w = rd_word(mdl, int'(mem_addr));
    mem_dq_i[7:0]  = (!mem_ce_n && mem_we_n && !mem_oe_n && !mem_lb_n) ? w[7:0]  : 8'hA5;
    mem_dq_i[15:8] = (!mem_ce_n && mem_we_n && !mem_oe_n && !mem_ub_n) ? w[15:8] : 8'hA5;
    p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n; p_dqoe = mem_dq_oe;
    p_lb = mem_lb_n; p_ub = mem_ub_n; p_addr = mem_addr; p_dq = mem_dq_o;
  end

  task automatic do_req(input logic wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] be, input bit hold,
                        output logic [15:0] rd, output int lat);
    bit first;
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
    lat = 0; first = 1;
    seen_lb = 1'b1; seen_ub = 1'b1;
    do begin
      @(negedge clk);
      lat++;
      if (first && !mem_ce_n) begin seen_lb = mem_lb_n; seen_ub = mem_ub_n; first = 0; end
    end while (!rdy && lat < 100);
    rd = rdata;
    chk(mem_ce_n == 1'b1, "R10 ce high in ready cycle", mem_ce_n, 1);
    if (hold) @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk(!rdy, "R9 ready single pulse", rdy, 0);
    chk(mem_ce_n == 1'b1, "R10 no re-accept", mem_ce_n, 1);
  endtask

  task automatic wr_op(input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] rd, w;
    int lat, exp_lat;
    exp_lat = last_was_rd ? LAT_WR_AFTER_RD : LAT_WR;
    do_req(1'b1, a, d, be, 1'b0, rd, lat);
    chk(lat == exp_lat, "R9 write latency", lat, exp_lat);
    w = rd_word(ref_m, int'(a));
    if (be[0]) w[7:0]  = d[7:0];
    if (be[1]) w[15:8] = d[15:8];
    ref_m[int'(a)] = w;
    last_was_rd = 1'b0;
  endtask

  task automatic rd_op(input logic [18:0] a, input logic [1:0] be, input string tag);
    logic [15:0] rd, exp;
    int lat;
    do_req(1'b0, a, 16'h0, be, 1'b0, rd, lat);
    exp = rd_word(ref_m, int'(a)) & {{8{be[1]}}, {8{be[0]}}};
    chk(rd == exp, tag, rd, exp);
    chk(lat == LAT_RD, "R9 read latency", lat, LAT_RD);
    chk({seen_ub, seen_lb} == ~be, "R4 lane strobes", {seen_ub, seen_lb}, ~be);
    last_was_rd = 1'b1;
  endtask

  task automatic t_reset;
    bit ok;
    repeat (3) @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111, "R1 strobes in reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
    chk(!mem_dq_oe && !rdy, "R1 bus and ready in reset", {mem_dq_oe, rdy}, 0);
    rst = 1'b0;
    ok = 1;
    repeat (6) begin
      @(negedge clk);
      if (!mem_ce_n || mem_dq_oe) ok = 0;
    end
    chk(ok, "R2 idle standby", ok, 1);
  endtask

  task automatic t_full;
    wr_op(19'h12345, 16'hBEEF, 2'b11);
    rd_op(19'h12345, 2'b11, "R3 full read");
    wr_op(19'h12346, 16'h0F0F, 2'b11);
    rd_op(19'h12346, 2'b11, "R3 read after turnaround write");
    wr_op(19'h7FFFF, 16'h8001, 2'b11);
    wr_op(19'h00000, 16'h7FFE, 2'b11);
    rd_op(19'h7FFFF, 2'b11, "R3 top address");
    rd_op(19'h00000, 2'b11, "R3 bottom address");
  endtask

  task automatic t_lanes;
    wr_op(19'h00100, 16'h1111, 2'b11);
    wr_op(19'h00100, 16'hAABB, 2'b01);
    rd_op(19'h00100, 2'b11, "R6 lower lane write");
    wr_op(19'h00100, 16'hCC00, 2'b10);
    rd_op(19'h00100, 2'b11, "R6 upper lane write");
    wr_op(19'h00100, 16'hFFFF, 2'b00);
    rd_op(19'h00100, 2'b11, "R6 no lane write");
    rd_op(19'h00100, 2'b01, "R4 lower lane read");
    rd_op(19'h00100, 2'b10, "R4 upper lane read");
    rd_op(19'h00100, 2'b00, "R4 no lane read");
  endtask

  task automatic t_hold;
    logic [15:0] rd;
    int lat;
    do_req(1'b0, 19'h00100, 16'h0, 2'b11, 1'b1, rd, lat);
    chk(rd == 16'hCCBB, "R10 held request read", rd, 16'hCCBB);
    last_was_rd = 1'b1;
  endtask

  task automatic t_mixed;
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[4]) wr_op(19'h40000 | 19'(lf[3:0]), lf ^ 16'h3C3C, lf[6:5]);
      else       rd_op(19'h40000 | 19'(lf[3:0]), lf[6:5], "R6 mixed read");
    end
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CK_NS * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    t_full();
    t_lanes();
    t_hold();
    t_mixed();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule